// File: doc/BRIEF.md
# Serial Memory Write Protection Guard

This block sits beside the command decoder of a serial nonvolatile memory and rules on every write the decoder wants to start. It keeps the write-enable latch and the nonvolatile configuration bits: a two-bit array protection field and a bit that arms the external write-protect pin. The decoder raises a one-cycle request for an array write (with its byte address) or for a configuration write (with its data byte). The guard answers one clock later with either a grant or a refusal pulse.

Array protection covers nothing, the top quarter, the top half or the whole array. The configuration bits are shielded by the write-protect pin only when the arming bit is set. A granted configuration write takes effect at the same edge that issues the grant. A refusal always drops the write-enable latch, and so does the end of a program cycle reported by the timing logic.

Top module: `wp_guard`

## Requirements
- R1: After reset the write-enable latch, the protection field and the arming bit are all 0 and no grant or refusal pulse is active.
- R2: A `wel_set` pulse sets the write-enable latch and a `wel_clr` pulse clears it; when both come in the same cycle, the clear wins.
- R3: Any array or configuration write request made while the write-enable latch is 0 is refused.
- R4: The protection field selects protected addresses: 00 none, 01 addresses 0x1800 to 0x1FFF, 10 addresses 0x1000 to 0x1FFF, 11 every address. An array write to a protected address is refused.
- R5: When `wp_n` is 0 and the arming bit is 1, a configuration write is refused and the configuration bits stay unchanged.
- R6: When the arming bit is 0, `wp_n` has no effect on configuration writes; when `wp_n` is 1, configuration writes are allowed whatever the arming bit holds.
- R7: A granted configuration write loads the arming bit from `sts_data[7]` and the protection field from `sts_data[3:2]`. The readback `stat` shows the arming bit on bit 7, the protection field on bits 3:2, the latch on bit 1, and 0 on every other bit.
- R8: A refusal clears the write-enable latch; it takes priority over a `wel_set` in the same cycle.
- R9: A `cycle_done` pulse clears the write-enable latch; it takes priority over a `wel_set` in the same cycle.
- R10: Each request produces exactly one of its grant or refusal pulse, one cycle after the request; no pulse appears without a request.
- R11: The configuration bits change only through a granted configuration write; movement on `wp_n` alone never alters them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Write-protect pin, 0 = protect |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch |
| arr_req | input | 1 | Array write request strobe |
| arr_addr | input | ADDR_W | Target byte address of the array write |
| sts_req | input | 1 | Configuration write request strobe |
| sts_data | input | 8 | Data byte of the configuration write |
| cycle_done | input | 1 | Program cycle finished |
| arr_ok | output | 1 | Array write granted |
| arr_deny | output | 1 | Array write refused |
| sts_ok | output | 1 | Configuration write granted |
| sts_deny | output | 1 | Configuration write refused |
| stat | output | 8 | Configuration and latch readback |

## Verification
Array writes are aimed at addresses just inside and just outside each protected region, under all four protection settings. This separates a correct boundary from one that is off by one region. Configuration writes are tried under all four combinations of pin level and arming bit, which shows that the pin is ignored when disarmed and honoured when armed. The latch is driven through set, clear, completion, refusal and their simultaneous combinations, which tells apart the priority order among them.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
    localparam int STAT_W       = 8;
    localparam int STAT_ARM_BIT = 7;
    localparam int STAT_BP_LO   = 2;
    localparam int STAT_WEL_BIT = 1;

    typedef struct packed {
        logic       wel;
        logic [1:0] bp;
        logic       arm;
        logic       arr_ok;
        logic       arr_deny;
        logic       sts_ok;
        logic       sts_deny;
    } guard_state_t;
endpackage

// File: rtl/wp_region_check.sv
module wp_region_check #(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    output logic              in_protected
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (bp)
            2'b00:   in_protected = 1'b0;
            2'b01:   in_protected = addr[TOP] & addr[TOP-1];
            2'b10:   in_protected = addr[TOP];
            default: in_protected = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_pin_lock.sv
module wp_pin_lock (
    input  logic wp_n,
    input  logic arm,
    output logic locked
);
    always_comb locked = arm & ~wp_n;
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              sts_req,
    input  logic [7:0]        sts_data,
    input  logic              cycle_done,
    output logic              arr_ok,
    output logic              arr_deny,
    output logic              sts_ok,
    output logic              sts_deny,
    output logic [STAT_W-1:0] stat
);
    guard_state_t st_q, st_d;
    logic in_prot, locked;

    wp_region_check #(.ADDR_W(ADDR_W)) u_region (
        .addr(arr_addr), .bp(st_q.bp), .in_protected(in_prot)
    );

    wp_pin_lock u_lock (
        .wp_n(wp_n), .arm(st_q.arm), .locked(locked)
    );

    always_comb begin
        logic arr_pass, sts_pass, refused;
        st_d          = st_q;
        arr_pass      = arr_req & st_q.wel & ~in_prot;
        sts_pass      = sts_req & st_q.wel & ~locked;
        refused       = (arr_req & ~arr_pass) | (sts_req & ~sts_pass);
        st_d.arr_ok   = arr_pass;
        st_d.arr_deny = arr_req & ~arr_pass;
        st_d.sts_ok   = sts_pass;
        st_d.sts_deny = sts_req & ~sts_pass;
        if (sts_pass) begin
            st_d.arm = sts_data[7];
            st_d.bp  = sts_data[3:2];
        end
        if (refused || wel_clr || cycle_done) st_d.wel = 1'b0;
        else if (wel_set)                     st_d.wel = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat                    = '0;
        stat[STAT_ARM_BIT]      = st_q.arm;
        stat[STAT_BP_LO+1 -: 2] = st_q.bp;
        stat[STAT_WEL_BIT]      = st_q.wel;
    end

    assign arr_ok   = st_q.arr_ok;
    assign arr_deny = st_q.arr_deny;
    assign sts_ok   = st_q.sts_ok;
    assign sts_deny = st_q.sts_deny;

    assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_ok && arr_deny) && !(sts_ok && sts_deny));
    assert_verdict_has_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_ok || arr_deny) |-> $past(arr_req));
    assert_grant_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_ok || sts_ok) |-> $past(stat[STAT_WEL_BIT]));
    assert_deny_drops_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_deny || sts_deny) |-> !stat[STAT_WEL_BIT]);
    assert_pin_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ok |-> !($past(stat[STAT_ARM_BIT]) && !$past(wp_n)));
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_ok |-> $stable({stat[STAT_ARM_BIT], stat[3:2]}));
    assert_cfg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ok |-> (stat[STAT_ARM_BIT] == $past(sts_data[7]) && stat[3:2] == $past(sts_data[3:2])));
    assert_all_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_ok |-> $past(stat[3:2]) != 2'b11);
endmodule

// File: tb/wp_guard_test.sv
module wp_guard_test;
    localparam int ADDR_W = 13;
    localparam int NV = 32;
    // fields: op(3) wp_n(1) addr(13) data(8) ok(1) deny(1) wel(1) bp(2) arm(1)
    // op: 0 idle, 1 set, 2 clr, 3 array write, 4 config write, 5 done
    localparam logic [30:0] VEC [NV] = '{
        {3'd3,1'b1,13'h0000,8'h00,1'b0,1'b1,1'b0,2'd0,1'b0}, // R3
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd0,1'b0}, // R2
        {3'd3,1'b1,13'h1FFF,8'h00,1'b1,1'b0,1'b1,2'd0,1'b0}, // R4 none
        {3'd5,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd0,1'b0}, // R9
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd0,1'b0},
        {3'd4,1'b1,13'h0000,8'h04,1'b1,1'b0,1'b1,2'd1,1'b0}, // R7
        {3'd5,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd1,1'b0},
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd1,1'b0},
        {3'd3,1'b1,13'h1800,8'h00,1'b0,1'b1,1'b0,2'd1,1'b0}, // R4 quarter
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd1,1'b0},
        {3'd3,1'b1,13'h17FF,8'h00,1'b1,1'b0,1'b1,2'd1,1'b0},
        {3'd5,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd1,1'b0},
        {3'd1,1'b0,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd1,1'b0},
        {3'd4,1'b0,13'h0000,8'h88,1'b1,1'b0,1'b1,2'd2,1'b1}, // R6 disarmed
        {3'd5,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd2,1'b1},
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd2,1'b1},
        {3'd3,1'b1,13'h1000,8'h00,1'b0,1'b1,1'b0,2'd2,1'b1}, // R4 half
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd2,1'b1},
        {3'd3,1'b1,13'h0FFF,8'h00,1'b1,1'b0,1'b1,2'd2,1'b1},
        {3'd5,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd2,1'b1},
        {3'd1,1'b0,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd2,1'b1},
        {3'd4,1'b0,13'h0000,8'h0C,1'b0,1'b1,1'b0,2'd2,1'b1}, // R5
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd2,1'b1},
        {3'd4,1'b1,13'h0000,8'h0C,1'b1,1'b0,1'b1,2'd3,1'b0}, // R6 pin high
        {3'd5,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd3,1'b0},
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd3,1'b0},
        {3'd3,1'b1,13'h0000,8'h00,1'b0,1'b1,1'b0,2'd3,1'b0}, // R4 all
        {3'd4,1'b1,13'h0000,8'h00,1'b0,1'b1,1'b0,2'd3,1'b0}, // R3
        {3'd2,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd3,1'b0},
        {3'd1,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,2'd3,1'b0},
        {3'd2,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd3,1'b0}, // R2
        {3'd0,1'b0,13'h0000,8'h00,1'b0,1'b0,1'b0,2'd3,1'b0}  // R11
    };

    logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
    logic wel_set = 0, wel_clr = 0, arr_req = 0, sts_req = 0, cycle_done = 0;
    logic [ADDR_W-1:0] arr_addr = '0;
    logic [7:0] sts_data = '0, stat;
    logic arr_ok, arr_deny, sts_ok, sts_deny;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    wp_guard #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .arr_req(arr_req), .arr_addr(arr_addr), .sts_req(sts_req), .sts_data(sts_data),
        .cycle_done(cycle_done), .arr_ok(arr_ok), .arr_deny(arr_deny),
        .sts_ok(sts_ok), .sts_deny(sts_deny), .stat(stat)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] pack(input logic ao, ad, so, sd, input logic [7:0] s);
        return {ao, ad, so, sd, s};
    endfunction

    task automatic clear_strobes();
        wel_set = 0; wel_clr = 0; arr_req = 0; sts_req = 0; cycle_done = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", pack(arr_ok, arr_deny, sts_ok, sts_deny, stat), 12'h000);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle after reset", pack(arr_ok, arr_deny, sts_ok, sts_deny, stat), 12'h000);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic ok, dn;
            logic [7:0] es;
            op = VEC[i][30:28];
            wp_n = VEC[i][27];
            arr_addr = VEC[i][26:14];
            sts_data = VEC[i][13:6];
            wel_set = (op == 3'd1); wel_clr = (op == 3'd2);
            arr_req = (op == 3'd3); sts_req = (op == 3'd4); cycle_done = (op == 3'd5);
            ok = VEC[i][5]; dn = VEC[i][4];
            es = {VEC[i][0], 3'b000, VEC[i][2:1], VEC[i][3], 1'b0};
            @(negedge clk);
            check($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R9 R10 R11)", i),
                  pack(arr_ok, arr_deny, sts_ok, sts_deny, stat),
                  pack(ok & (op == 3'd3), dn & (op == 3'd3), ok & (op == 3'd4), dn & (op == 3'd4), es));
            clear_strobes();
        end

        // R8: refusal beats a same-cycle set (bp=11 still active)
        wp_n = 1; wel_set = 1; arr_req = 1; arr_addr = 13'h0010;
        @(negedge clk);
        check("R8 deny beats set", pack(arr_ok, arr_deny, sts_ok, sts_deny, stat), pack(0, 1, 0, 0, 8'h0C));
        clear_strobes();
        // R2: set and clear together
        wel_set = 1; wel_clr = 1;
        @(negedge clk);
        check("R2 clear wins", {4'h0, stat}, {4'h0, 8'h0C});
        clear_strobes();
        // R9: done beats set
        wel_set = 1; cycle_done = 1;
        @(negedge clk);
        check("R9 done wins", {4'h0, stat}, {4'h0, 8'h0C});
        clear_strobes();
        // R10: idle cycle, no verdict
        @(negedge clk);
        check("R10 no pulse", pack(arr_ok, arr_deny, sts_ok, sts_deny, 8'h00), 12'h000);
        // R11: arm then toggle pin, config unchanged
        wel_set = 1; @(negedge clk); clear_strobes();
        sts_req = 1; sts_data = 8'h80; @(negedge clk); clear_strobes();
        check("R7 arm load", {4'h0, stat}, {4'h0, 8'h82});
        wp_n = 0; @(negedge clk); wp_n = 1; @(negedge clk);
        check("R11 pin toggle", {4'h0, stat}, {4'h0, 8'h82});
        // R1: reset mid-state
        rst_n = 0; @(negedge clk);
        check("R1 reset clears", pack(arr_ok, arr_deny, sts_ok, sts_deny, stat), 12'h000);
        rst_n = 1; @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule